// File: doc/BRIEF.md
# Dual-Width Flash Bus Interface

This block is the synchronous front end of a small boot-block flash model. It samples a parallel external bus on every clock. The bus carries active-low chip enable, output enable and write enable, a word/byte width select, an encoded reset/power-down level and a flag that stands for a high voltage on the signature address pin. The block connects that bus to an internal array of 16-bit words. Reads are registered, so the data appears one clock after the bus asks for it. The block also produces a per-bit drive enable for every data line, which models the tri-state behaviour of the data pins.

A write is taken when write enable rises while chip enable is low. The address and data of that write are latched and handed to a small command stub. The stub knows three things: a program-setup code, a code that clears the protect error, and the data cycle that follows a program setup. A write into the boot range is allowed only when the power level is the unlock level. A boot write at any other level sets a protect-error flag and leaves the array unchanged.

The bus can never stall. There is no back-pressure: the latched write is a single-cycle valid pulse, and the stub accepts that pulse in every cycle.

Top module: `fbi_flash_bus`

## Requirements
- R1: One clock after chip enable is high, output enable is high, or the power level is off (`pwr_lvl` = 2'b00), `dq_oe` is all zero.
- R2: In word mode (`word_mode` = 1), a read with `ce_n` = `oe_n` = 0 returns the addressed array word on `dq_out` one clock later, with `dq_oe` = 16'hFFFF.
- R3: In byte mode (`word_mode` = 0), `dq_in[15]` is the lowest address bit: 1 selects the upper byte and 0 selects the lower byte. The selected byte appears on `dq_out[7:0]` one clock later, with `dq_oe` = 16'h00FF.
- R4: While `sig_hv` = 1, a read returns the signature. `addr[0]` = 0 selects the manufacturer ID and 1 selects the device ID. In byte mode only the low byte of the signature is driven, and `dq_in[15]` has no effect.
- R5: A write is latched when `we_n` rises with `ce_n` low. If the preceding latched write carried 8'h40 in its low byte, this second write programs the array. In word mode it programs the full word.
- R6: A byte-mode program changes only the byte lane selected by `dq_in[15]`, with the data taken from `dq_in[7:0]`. The other lane of the word keeps its value.
- R7: A latched write that follows no program setup never changes the array. The byte value 8'h50 in such a write clears the protect error.
- R8: A program into the boot range [BOOT_LO, BOOT_HI] leaves the array unchanged and sets `prot_err` unless `pwr_lvl` = 2'b10. At level 2'b10 the program is performed. Levels 2'b01 and 2'b11 both keep the boot range locked.
- R9: While `pwr_lvl` = 2'b00, bus writes are ignored, `prot_err` clears and a pending program setup is abandoned. On leaving that level the block is in read-array mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; latches on rising edge |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| pwr_lvl | input | 2 | 00 off/power-down, 01 normal high, 10 unlock high voltage, 11 treated as normal |
| sig_hv | input | 1 | High-voltage flag on the signature address pin |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data lines as seen by the block (bit 15 is the byte address in byte mode) |
| dq_out | output | 16 | Data the block drives |
| dq_oe | output | 16 | Per-line drive enable; 0 means floating |
| prot_err | output | 1 | Protect error after a locked boot program |

## Verification
The bench uses the default parameters: a 5-bit address (32 words), with the boot range at words 28 to 31. At this size every word can be programmed and read back in word mode, and every one of the 64 bytes can be read in byte mode. The bench compares each result against values computed from arithmetic formulas of the address. It also covers both signature selections in both widths, boot writes at each lock level, and power-down entered with a program setup pending.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  typedef enum logic [1:0] {
    PWR_OFF    = 2'b00,
    PWR_NORM   = 2'b01,
    PWR_UNLOCK = 2'b10,
    PWR_RSVD   = 2'b11
  } pwr_lvl_e;

  typedef enum logic {ST_READ, ST_SETUP} cmd_st_e;

  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_CLR_ERR    = 8'h50;
endpackage

// File: rtl/fbi_wr_capture.sv
module fbi_wr_capture #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          pd,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr,
  output logic [1:0]    cap_lanes,
  output logic [15:0]   cap_data
);
  logic we_n_q;
  logic we_rise;

  assign we_rise = !we_n_q && we_n && !ce_n && !pd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_n_q    <= 1'b1;
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_lanes <= '0;
      cap_data  <= '0;
    end else begin
      we_n_q    <= we_n;
      cap_valid <= we_rise;
      if (we_rise) begin
        cap_addr <= addr;
        if (word_mode) begin
          cap_lanes <= 2'b11;
          cap_data  <= dq_in;
        end else begin
          cap_lanes <= dq_in[15] ? 2'b10 : 2'b01;
          cap_data  <= {dq_in[7:0], dq_in[7:0]};
        end
      end
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid);
  a_r9_no_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !cap_valid);
endmodule

// File: rtl/fbi_cmd_stub.sv
module fbi_cmd_stub
  import fbi_pkg::*;
#(
  parameter int AW      = 5,
  parameter int BOOT_LO = 28,
  parameter int BOOT_HI = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd,
  input  logic          unlock,
  input  logic          cap_valid,
  input  logic [AW-1:0] cap_addr,
  input  logic [1:0]    cap_lanes,
  input  logic [15:0]   cap_data,
  output logic [1:0]    mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          prot_err
);
  localparam logic [AW-1:0] B_LO = AW'(BOOT_LO);
  localparam logic [AW-1:0] B_HI = AW'(BOOT_HI);

  cmd_st_e st;
  logic    boot_hit;
  logic    blocked;
  logic    do_prog;

  assign boot_hit  = (cap_addr >= B_LO) && (cap_addr <= B_HI);
  assign blocked   = boot_hit && !unlock;
  assign do_prog   = cap_valid && (st == ST_SETUP) && !pd;
  assign mem_we    = (do_prog && !blocked) ? cap_lanes : 2'b00;
  assign mem_addr  = cap_addr;
  assign mem_wdata = cap_data;

  always_ff @(posedge clk) begin
    if (!rst_n || pd) begin
      st       <= ST_READ;
      prot_err <= 1'b0;
    end else if (cap_valid) begin
      case (st)
        ST_SETUP: begin
          st <= ST_READ;
          if (blocked) prot_err <= 1'b1;
        end
        default: begin
          if (cap_data[7:0] == CMD_PROG_SETUP) st <= ST_SETUP;
          else if (cap_data[7:0] == CMD_CLR_ERR) prot_err <= 1'b0;
        end
      endcase
    end
  end

  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_err) |-> ($past(cap_valid) && !$past(unlock)));
  a_r7_setup_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_SETUP) |-> $past(cap_valid && cap_data[7:0] == CMD_PROG_SETUP));
endmodule

// File: rtl/fbi_read_path.sv
module fbi_read_path #(
  parameter int          AW     = 5,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h2275
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pd,
  input  logic          word_mode,
  input  logic          sig_hv,
  input  logic [AW-1:0] addr,
  input  logic          dq_hi_in,
  input  logic [15:0]   arr_word,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe
);
  logic        rd_en;
  logic [15:0] src_word;
  logic [15:0] nxt_data;

  assign rd_en = !ce_n && !oe_n && !pd;

  always_comb begin
    if (sig_hv) src_word = addr[0] ? DEV_ID : MFR_ID;
    else        src_word = arr_word;
    if (word_mode)               nxt_data = src_word;
    else if (sig_hv || !dq_hi_in) nxt_data = {8'h00, src_word[7:0]};
    else                         nxt_data = {8'h00, src_word[15:8]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (rd_en) begin
      dq_out <= nxt_data;
      dq_oe  <= word_mode ? 16'hFFFF : 16'h00FF;
    end else begin
      dq_oe  <= '0;
    end
  end

  a_r1_float: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || pd) |=> (dq_oe == 16'h0000));
  a_r3_low_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !word_mode) |=> (dq_oe == 16'h00FF));
endmodule

// File: rtl/fbi_flash_bus.sv
module fbi_flash_bus
  import fbi_pkg::*;
#(
  parameter int          AW      = 5,
  parameter int          BOOT_LO = 28,
  parameter int          BOOT_HI = 31,
  parameter logic [15:0] MFR_ID  = 16'h0089,
  parameter logic [15:0] DEV_ID  = 16'h2275
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_mode,
  input  logic [1:0]    pwr_lvl,
  input  logic          sig_hv,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe,
  output logic          prot_err
);
  localparam int DEPTH = 1 << AW;

  pwr_lvl_e      lvl;
  logic          pd;
  logic          unlock;
  logic          cap_valid;
  logic [AW-1:0] cap_addr;
  logic [1:0]    cap_lanes;
  logic [15:0]   cap_data;
  logic [1:0]    mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [7:0]    lane_rd [2];
  logic [15:0]   arr_word;

  assign lvl    = pwr_lvl_e'(pwr_lvl);
  assign pd     = (lvl == PWR_OFF);
  assign unlock = (lvl == PWR_UNLOCK);

  fbi_wr_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .pd(pd),
    .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_lanes(cap_lanes),
    .cap_data(cap_data)
  );

  fbi_cmd_stub #(.AW(AW), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)) u_cmd (
    .clk(clk), .rst_n(rst_n), .pd(pd), .unlock(unlock),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_lanes(cap_lanes),
    .cap_data(cap_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .prot_err(prot_err)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (mem_we[g]) lane_mem[mem_addr] <= mem_wdata[g*8 +: 8];
    end
    assign lane_rd[g] = lane_mem[addr];
  end

  assign arr_word = {lane_rd[1], lane_rd[0]};

  fbi_read_path #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pd(pd),
    .word_mode(word_mode), .sig_hv(sig_hv), .addr(addr),
    .dq_hi_in(dq_in[15]), .arr_word(arr_word),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: tb/fbi_flash_bus_test.sv
module fbi_flash_bus_test;
  localparam int          AW    = 5;
  localparam int          DEPTH = 32;
  localparam logic [15:0] MFR   = 16'h0089;
  localparam logic [15:0] DEV   = 16'h2275;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, ce_n, oe_n, we_n, word_mode, sig_hv, prot_err;
  logic [1:0]    pwr_lvl;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in, dq_out, dq_oe;

  fbi_flash_bus uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .pwr_lvl(pwr_lvl), .sig_hv(sig_hv), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .prot_err(prot_err)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [15:0] exp_mem [DEPTH];
  logic [15:0] q, o;

  function automatic logic [15:0] pat(int i);
    return 16'(i * 16'h0911) ^ 16'hA5C3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; dq_in = d; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    wr(a, {d[15], 7'b0, 8'h40});
    wr(a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic lsb,
                    output logic [15:0] rq, output logic [15:0] ro);
    @(negedge clk); addr = a; dq_in[15] = lsb; ce_n = 0; oe_n = 0;
    @(negedge clk); rq = dq_out; ro = dq_oe; oe_n = 1; ce_n = 1;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; word_mode = 1;
    pwr_lvl = 2'b01; sig_hv = 0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    check("R1 reset dq_oe", 32'(dq_oe), 32'h0);
    check("R8 reset prot_err", 32'(prot_err), 32'h0);
    rst_n = 1;

    // R5 / R2: full word program and read-back sweep, unlocked
    pwr_lvl = 2'b10;
    for (int i = 0; i < DEPTH; i++) begin
      prog(AW'(i), pat(i));
      exp_mem[i] = pat(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), 1'b0, q, o);
      check("R2/R5 word data", 32'(q), 32'(exp_mem[i]));
      check("R2 word oe", 32'(o), 32'hFFFF);
    end

    // R3: every byte in byte mode
    word_mode = 0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int b = 0; b < 2; b++) begin
        rd(AW'(i), b[0], q, o);
        check("R3 byte data", 32'(q[7:0]), 32'(b ? exp_mem[i][15:8] : exp_mem[i][7:0]));
        check("R3 byte oe", 32'(o), 32'h00FF);
      end
    end

    // R6: byte-lane programs
    for (int i = 0; i < 28; i++) begin
      prog(AW'(i), {1'b1, 7'b0, 8'(i * 7 + 1)});
      exp_mem[i][15:8] = 8'(i * 7 + 1);
    end
    prog(AW'(29), {1'b0, 7'b0, 8'h3C});
    exp_mem[29][7:0] = 8'h3C;
    word_mode = 1;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), 1'b0, q, o);
      check("R6 lane merge", 32'(q), 32'(exp_mem[i]));
    end

    // R4: signatures
    sig_hv = 1;
    rd(AW'(0), 1'b0, q, o); check("R4 mfr word", 32'(q), 32'(MFR));
    rd(AW'(1), 1'b0, q, o); check("R4 dev word", 32'(q), 32'(DEV));
    word_mode = 0;
    rd(AW'(1), 1'b1, q, o); check("R4 dev byte", 32'(q[7:0]), 32'(DEV[7:0]));
    check("R4 byte oe", 32'(o), 32'h00FF);
    rd(AW'(0), 1'b1, q, o); check("R4 mfr byte", 32'(q[7:0]), 32'(MFR[7:0]));
    sig_hv = 0; word_mode = 1;

    // R7: writes without setup change nothing
    wr(AW'(3), 16'hBEEF);
    wr(AW'(3), 16'h00FF);
    rd(AW'(3), 1'b0, q, o); check("R7 no setup", 32'(q), 32'(exp_mem[3]));

    // R8: boot lock
    pwr_lvl = 2'b01;
    prog(AW'(30), 16'h1111);
    check("R8 err set", 32'(prot_err), 32'h1);
    rd(AW'(30), 1'b0, q, o); check("R8 locked boot", 32'(q), 32'(exp_mem[30]));
    prog(AW'(5), 16'h5555); exp_mem[5] = 16'h5555;
    rd(AW'(5), 1'b0, q, o); check("R8 normal area", 32'(q), 32'h5555);
    wr(AW'(0), 16'h0050);
    check("R7 clear err", 32'(prot_err), 32'h0);
    pwr_lvl = 2'b11;
    prog(AW'(28), 16'h2828);
    check("R8 level 11 locks", 32'(prot_err), 32'h1);
    rd(AW'(28), 1'b0, q, o); check("R8 level 11 data", 32'(q), 32'(exp_mem[28]));
    wr(AW'(0), 16'h0050);
    pwr_lvl = 2'b10;
    prog(AW'(31), 16'h7777); exp_mem[31] = 16'h7777;
    rd(AW'(31), 1'b0, q, o); check("R8 unlocked boot", 32'(q), 32'h7777);
    check("R8 no err unlocked", 32'(prot_err), 32'h0);

    // R1: deselect / output disable
    @(negedge clk); ce_n = 1; oe_n = 0;
    @(negedge clk); check("R1 ce high", 32'(dq_oe), 32'h0);
    ce_n = 0; oe_n = 1;
    @(negedge clk); check("R1 oe high", 32'(dq_oe), 32'h0);
    ce_n = 1;

    // R9: power-down
    pwr_lvl = 2'b01;
    prog(AW'(30), 16'h3030);
    check("R8 err before off", 32'(prot_err), 32'h1);
    @(negedge clk); pwr_lvl = 2'b00;
    @(negedge clk); check("R9 err cleared", 32'(prot_err), 32'h0);
    rd(AW'(2), 1'b0, q, o); check("R9 float off", 32'(o), 32'h0);
    prog(AW'(2), 16'h2222);
    pwr_lvl = 2'b01;
    rd(AW'(2), 1'b0, q, o); check("R9 write ignored", 32'(q), 32'(exp_mem[2]));
    wr(AW'(7), 16'h0040);
    @(negedge clk); pwr_lvl = 2'b00;
    @(negedge clk); pwr_lvl = 2'b01;
    wr(AW'(7), 16'h1234);
    rd(AW'(7), 1'b0, q, o); check("R9 setup abandoned", 32'(q), 32'(exp_mem[7]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule